// File: doc/BRIEF.md
# Variable-Length 16-bit x86 Subset Instruction Decoder

The block turns a byte stream of a small 16-bit x86 instruction subset into one structured record per instruction. Software or a sequencer pulses `start_i` with an instruction pointer. The decoder then fetches bytes one at a time through a request/valid port. It walks the opcode byte, then the optional addressing byte, any 8- or 16-bit displacement, and any 8- or 16-bit immediate. When it has the whole instruction, it raises `done_o` for one cycle with the decoded fields and the pointer of the following instruction.

The supported subset covers MOV in its register/memory, immediate-to-register/memory, immediate-to-register and accumulator/direct-memory forms, and ADD, SUB and CMP in their register/memory, immediate-group and accumulator-immediate forms. It also covers conditional jumps and loop-type jumps. Effective-address arithmetic, execution and flag updates belong to later stages. A memory operand is reported as a base code plus a 16-bit displacement.

Top module: `ixd_decoder`

## Requirements
- R1: After reset `done_o`, `req_o` and `err_o` are 0.
- R2: Opcode 100010dw and ALU register forms 00fff0dw (fff = 000 ADD, 101 SUB, 111 CMP) read an addressing byte laid out as mod[7:6], reg[5:3], rm[2:0]. When d=1 the reg field is the destination and the rm operand is the source; when d=0 the roles swap. `wide_o` equals w. Op codes are MOV=0, ADD=1, SUB=2, CMP=3, JCC=4, LOOP=5. Operand kinds are register=0, memory=1, immediate=2 (source only), none=2 for the destination and none=3 for the source.
- R3: mod=11 makes rm a register operand. mod=10 is followed by a 16-bit little-endian displacement. mod=01 is followed by one byte that is sign-extended to 16 bits.
- R4: mod=00 with rm=110 reports base code 8 (direct) and takes a 16-bit little-endian address into `disp_o`. Any other mod=00 uses base code rm with displacement 0.
- R5: Opcode 1100011w moves an immediate into the rm operand. The immediate follows any displacement and is one byte (zero-extended) when w=0, or two little-endian bytes when w=1.
- R6: Opcode 100000sw selects ADD, SUB or CMP by reg field 000, 101 or 111. With s=1 and w=1, one immediate byte is sign-extended. Any other reg field sets `err_o` after two bytes.
- R7: Opcode 0111cccc gives op JCC, `cond_o`=cccc and `jofs_o` set to the following byte.
- R8: Opcode 111000cc gives op LOOP, `cond_o`=00cc and `jofs_o` set to the following byte.
- R9: Opcode 1010000w loads the accumulator (register 0) from a direct 16-bit address. Opcode 1010001w stores it to that address.
- R10: Opcode 1011wrrr loads register rrr with an immediate of one byte (w=0) or two bytes (w=1).
- R11: `ip_o` at `done_o` equals the start pointer plus the bytes consumed, and `done_o` is high for exactly one cycle per instruction.
- R12: A first byte that matches no supported pattern sets `err_o` with `done_o` after consuming one byte.
- R13: `req_o` stays high with a stable `req_addr_o` until `mem_valid_i` is seen. Each accepted byte advances the address by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin decoding at `start_ip_i` (accepted when idle) |
| start_ip_i | input | IP_W | Pointer of the first byte |
| req_o | output | 1 | Byte fetch request |
| req_addr_o | output | IP_W | Address of the requested byte |
| mem_valid_i | input | 1 | Requested byte is present this cycle |
| mem_byte_i | input | 8 | Fetched byte |
| done_o | output | 1 | Record valid, one cycle |
| err_o | output | 1 | Decode error in this record |
| op_o | output | 3 | Operation code |
| dst_kind_o | output | 2 | Destination kind |
| dst_reg_o | output | 3 | Destination register number |
| src_kind_o | output | 2 | Source kind |
| src_reg_o | output | 3 | Source register number |
| mem_base_o | output | 4 | Memory base code (rm, or 8 for direct) |
| disp_o | output | 16 | Displacement or direct address |
| imm_o | output | 16 | Immediate value |
| wide_o | output | 1 | 16-bit operation |
| cond_o | output | 4 | Jump condition code |
| jofs_o | output | 8 | Signed jump offset |
| ip_o | output | IP_W | Pointer past the instruction |

## Verification
Several things can fall in the same cycle: the last byte of one field is accepted, the pointer advances, and the state moves to the next field. A stall can also land in that cycle. The bench withholds `mem_valid_i` on a rotating phase so that stalls fall on opcode, addressing, displacement and immediate bytes alike. Each record is then judged against queued expectations for every field and the final pointer. A stall that caused a skipped or repeated byte would show up as a wrong field or a wrong `ip_o`.

// File: rtl/ixd_pkg.sv
package ixd_pkg;

   localparam logic [2:0] OP_MOV  = 3'd0;
   localparam logic [2:0] OP_ADD  = 3'd1;
   localparam logic [2:0] OP_SUB  = 3'd2;
   localparam logic [2:0] OP_CMP  = 3'd3;
   localparam logic [2:0] OP_JCC  = 3'd4;
   localparam logic [2:0] OP_LOOP = 3'd5;

   localparam logic [1:0] K_REG  = 2'd0;
   localparam logic [1:0] K_MEM  = 2'd1;
   localparam logic [1:0] K_IMM  = 2'd2;
   localparam logic [1:0] KD_NONE = 2'd2;
   localparam logic [1:0] KS_NONE = 2'd3;

   localparam logic [3:0] BASE_DIRECT = 4'd8;

   typedef enum logic [3:0] {
      C_BAD, C_RM_REG, C_RM_IMM, C_GRP_IMM, C_REG_IMM,
      C_ACC_MEM, C_ACC_IMM, C_JCC, C_LOOP
   } ixd_cls_e;

   // {ok, op} for the three-bit arithmetic selector
   function automatic logic [3:0] alu_sel(input logic [2:0] f);
      case (f)
         3'b000:  alu_sel = {1'b1, OP_ADD};
         3'b101:  alu_sel = {1'b1, OP_SUB};
         3'b111:  alu_sel = {1'b1, OP_CMP};
         default: alu_sel = {1'b0, OP_MOV};
      endcase
   endfunction

endpackage

// File: rtl/ixd_classify.sv
module ixd_classify
   import ixd_pkg::*;
#(
   parameter bit ACC_ALU_EN = 1'b1
) (
   input  logic [7:0] opc_i,
   output ixd_cls_e   cls_o,
   output logic [2:0] op_o,
   output logic       w_o,
   output logic       d_o
);

   logic [3:0] alu;
   logic       acc_hit;
   logic       rm_alu_hit;

   assign alu        = alu_sel(opc_i[5:3]);
   assign rm_alu_hit = (opc_i[7:6] == 2'b00) && !opc_i[2] && alu[3];

   generate
      if (ACC_ALU_EN) begin : g_acc
         assign acc_hit = (opc_i[7:6] == 2'b00) && (opc_i[2:1] == 2'b10) && alu[3];
      end else begin : g_noacc
         assign acc_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      cls_o = C_BAD;
      op_o  = OP_MOV;
      w_o   = opc_i[0];
      d_o   = opc_i[1];
      if (opc_i[7:2] == 6'b100010) begin
         cls_o = C_RM_REG;
      end else if (opc_i[7:1] == 7'b1100011) begin
         cls_o = C_RM_IMM;
      end else if (opc_i[7:2] == 6'b100000) begin
         cls_o = C_GRP_IMM;
      end else if (opc_i[7:4] == 4'b1011) begin
         cls_o = C_REG_IMM;
         w_o   = opc_i[3];
      end else if (opc_i[7:2] == 6'b101000) begin
         cls_o = C_ACC_MEM;
      end else if (opc_i[7:4] == 4'b0111) begin
         cls_o = C_JCC;
         op_o  = OP_JCC;
         w_o   = 1'b0;
      end else if (opc_i[7:2] == 6'b111000) begin
         cls_o = C_LOOP;
         op_o  = OP_LOOP;
         w_o   = 1'b0;
      end else if (rm_alu_hit) begin
         cls_o = C_RM_REG;
         op_o  = alu[2:0];
      end else if (acc_hit) begin
         cls_o = C_ACC_IMM;
         op_o  = alu[2:0];
      end
   end

endmodule

// File: rtl/ixd_modrm.sv
module ixd_modrm
   import ixd_pkg::*;
(
   input  logic [7:0] mrm_i,
   output logic       is_reg_o,
   output logic [2:0] reg_f_o,
   output logic [2:0] rm_o,
   output logic [3:0] base_o,
   output logic [1:0] disp_len_o
);

   logic [1:0] md;
   logic       direct;

   assign md       = mrm_i[7:6];
   assign reg_f_o  = mrm_i[5:3];
   assign rm_o     = mrm_i[2:0];
   assign is_reg_o = (md == 2'b11);
   assign direct   = (md == 2'b00) && (mrm_i[2:0] == 3'b110);
   assign base_o   = direct ? BASE_DIRECT : {1'b0, mrm_i[2:0]};

   always_comb begin
      case (md)
         2'b01:   disp_len_o = 2'd1;
         2'b10:   disp_len_o = 2'd2;
         2'b00:   disp_len_o = direct ? 2'd2 : 2'd0;
         default: disp_len_o = 2'd0;
      endcase
   end

endmodule

// File: rtl/ixd_decoder.sv
module ixd_decoder
   import ixd_pkg::*;
#(
   parameter int IP_W       = 16,
   parameter bit ACC_ALU_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [IP_W-1:0] start_ip_i,
   output logic            req_o,
   output logic [IP_W-1:0] req_addr_o,
   input  logic            mem_valid_i,
   input  logic [7:0]      mem_byte_i,
   output logic            done_o,
   output logic            err_o,
   output logic [2:0]      op_o,
   output logic [1:0]      dst_kind_o,
   output logic [2:0]      dst_reg_o,
   output logic [1:0]      src_kind_o,
   output logic [2:0]      src_reg_o,
   output logic [3:0]      mem_base_o,
   output logic [15:0]     disp_o,
   output logic [15:0]     imm_o,
   output logic            wide_o,
   output logic [3:0]      cond_o,
   output logic [7:0]      jofs_o,
   output logic [IP_W-1:0] ip_o
);

   localparam logic [IP_W-1:0] IP_ONE = {{(IP_W-1){1'b0}}, 1'b1};

   generate
      if (IP_W < 8 || IP_W > 32) begin : g_bad_ipw
         $error("ixd_decoder: IP_W must lie in 8..32");
      end
   endgenerate

   typedef enum logic [3:0] {
      S_IDLE, S_OP, S_MODRM, S_DLO, S_DHI, S_ILO, S_IHI, S_JOFS, S_DONE
   } st_e;

   st_e             st;
   logic [IP_W-1:0] ptr;
   ixd_cls_e        cls_q;
   logic            w_q, d_q, s_q, two_q;
   logic [1:0]      mod_q;
   logic [2:0]      op_q, dreg_q, sreg_q;
   logic [1:0]      dk_q, sk_q;
   logic [3:0]      base_q, cond_q;
   logic [15:0]     disp_q, imm_q;
   logic [7:0]      jofs_q;
   logic            wide_q, err_q;

   ixd_cls_e        c_cls;
   logic [2:0]      c_op;
   logic            c_w, c_d;
   logic            m_isreg;
   logic [2:0]      m_reg, m_rm;
   logic [3:0]      m_base;
   logic [1:0]      m_dlen;
   logic [3:0]      grp;
   logic            take, need_imm, imm_two;
   logic [7:0]      b;

   ixd_classify #(.ACC_ALU_EN(ACC_ALU_EN)) u_cls (
      .opc_i(mem_byte_i), .cls_o(c_cls), .op_o(c_op), .w_o(c_w), .d_o(c_d)
   );

   ixd_modrm u_mrm (
      .mrm_i(mem_byte_i), .is_reg_o(m_isreg), .reg_f_o(m_reg), .rm_o(m_rm),
      .base_o(m_base), .disp_len_o(m_dlen)
   );

   assign b        = mem_byte_i;
   assign grp      = alu_sel(m_reg);
   assign req_o    = (st != S_IDLE) && (st != S_DONE);
   assign take     = req_o && mem_valid_i;
   assign need_imm = (cls_q == C_RM_IMM) || (cls_q == C_GRP_IMM);
   assign imm_two  = w_q && !((cls_q == C_GRP_IMM) && s_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE;   ptr <= '0;      cls_q <= C_BAD;
         w_q <= 1'b0;    d_q <= 1'b0;    s_q <= 1'b0;    two_q <= 1'b0;
         mod_q <= 2'b00; op_q <= OP_MOV; dreg_q <= '0;   sreg_q <= '0;
         dk_q <= KD_NONE; sk_q <= KS_NONE; base_q <= '0; cond_q <= '0;
         disp_q <= '0;   imm_q <= '0;    jofs_q <= '0;
         wide_q <= 1'b0; err_q <= 1'b0;
      end else begin
         case (st)
            S_IDLE: if (start_i) begin
               ptr <= start_ip_i; st <= S_OP;
               mod_q <= 2'b00; op_q <= OP_MOV; dreg_q <= '0; sreg_q <= '0;
               dk_q <= KD_NONE; sk_q <= KS_NONE; base_q <= '0; cond_q <= '0;
               disp_q <= '0; imm_q <= '0; jofs_q <= '0;
               wide_q <= 1'b0; err_q <= 1'b0;
            end
            S_DONE: st <= S_IDLE;
            default: if (take) begin
               ptr <= ptr + IP_ONE;
               case (st)
                  S_OP: begin
                     cls_q <= c_cls; w_q <= c_w; d_q <= c_d; s_q <= c_d;
                     op_q <= c_op; wide_q <= c_w;
                     case (c_cls)
                        C_BAD: begin err_q <= 1'b1; st <= S_DONE; end
                        C_REG_IMM: begin
                           dk_q <= K_REG; dreg_q <= b[2:0]; sk_q <= K_IMM; st <= S_ILO;
                        end
                        C_ACC_IMM: begin
                           dk_q <= K_REG; dreg_q <= 3'd0; sk_q <= K_IMM; st <= S_ILO;
                        end
                        C_ACC_MEM: begin
                           base_q <= BASE_DIRECT; two_q <= 1'b1; st <= S_DLO;
                           if (b[1]) begin
                              dk_q <= K_MEM; sk_q <= K_REG; sreg_q <= 3'd0;
                           end else begin
                              dk_q <= K_REG; dreg_q <= 3'd0; sk_q <= K_MEM;
                           end
                        end
                        C_JCC:   begin cond_q <= b[3:0]; st <= S_JOFS; end
                        C_LOOP:  begin cond_q <= {2'b00, b[1:0]}; st <= S_JOFS; end
                        default: st <= S_MODRM;
                     endcase
                  end
                  S_MODRM: begin
                     if ((cls_q == C_GRP_IMM) && !grp[3]) begin
                        err_q <= 1'b1; st <= S_DONE;
                     end else begin
                        mod_q  <= b[7:6];
                        base_q <= m_isreg ? 4'd0 : m_base;
                        if (cls_q == C_GRP_IMM) op_q <= grp[2:0];
                        if ((cls_q == C_RM_REG) && d_q) begin
                           dk_q <= K_REG; dreg_q <= m_reg;
                           sk_q <= m_isreg ? K_REG : K_MEM;
                           sreg_q <= m_isreg ? m_rm : 3'd0;
                        end else begin
                           dk_q <= m_isreg ? K_REG : K_MEM;
                           dreg_q <= m_isreg ? m_rm : 3'd0;
                           if (cls_q == C_RM_REG) begin
                              sk_q <= K_REG; sreg_q <= m_reg;
                           end else begin
                              sk_q <= K_IMM;
                           end
                        end
                        two_q <= (m_dlen == 2'd2);
                        if (m_dlen != 2'd0)   st <= S_DLO;
                        else if (need_imm)    st <= S_ILO;
                        else                  st <= S_DONE;
                     end
                  end
                  S_DLO: begin
                     if (two_q) begin
                        disp_q[7:0] <= b; st <= S_DHI;
                     end else begin
                        disp_q <= {{8{b[7]}}, b};
                        st <= need_imm ? S_ILO : S_DONE;
                     end
                  end
                  S_DHI: begin
                     disp_q[15:8] <= b;
                     st <= need_imm ? S_ILO : S_DONE;
                  end
                  S_ILO: begin
                     if (imm_two) begin
                        imm_q[7:0] <= b; st <= S_IHI;
                     end else begin
                        imm_q <= w_q ? {{8{b[7]}}, b} : {8'h00, b};
                        st <= S_DONE;
                     end
                  end
                  S_IHI:  begin imm_q[15:8] <= b; st <= S_DONE; end
                  S_JOFS: begin jofs_q <= b; st <= S_DONE; end
                  default: st <= S_IDLE;
               endcase
            end
         endcase
      end
   end

   assign req_addr_o = ptr;
   assign ip_o       = ptr;
   assign done_o     = (st == S_DONE);
   assign err_o      = err_q;
   assign op_o       = op_q;
   assign dst_kind_o = dk_q;
   assign dst_reg_o  = dreg_q;
   assign src_kind_o = sk_q;
   assign src_reg_o  = sreg_q;
   assign mem_base_o = base_q;
   assign disp_o     = disp_q;
   assign imm_o      = imm_q;
   assign wide_o     = wide_q;
   assign cond_o     = cond_q;
   assign jofs_o     = jofs_q;

   // Fetch port holds its request until served (R13)
   p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      req_o && !mem_valid_i |=> req_o && $stable(req_addr_o));

   // Consecutive requests walk forward one byte (R13)
   p_addr_step_r13: assert property (@(posedge clk) disable iff (!rst_n)
      req_o && mem_valid_i |=> !req_o || (req_addr_o == $past(req_addr_o) + IP_ONE));

   p_done_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_noreq_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !req_o);

   // A one-byte displacement arrives sign-extended (R3)
   p_disp8_sext_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !err_o && (mod_q == 2'b01) |-> disp_o[15:8] == {8{disp_o[7]}});

   // Direct base only ever tags a memory operand (R4)
   p_direct_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !err_o && (mem_base_o == BASE_DIRECT) |->
         (dst_kind_o == K_MEM) || (src_kind_o == K_MEM));

endmodule

// File: tb/sim_ixd_decoder.sv
module sim_ixd_decoder;

   typedef struct {
      logic [2:0]  op;
      logic [1:0]  dk;
      logic [2:0]  dreg;
      logic [1:0]  sk;
      logic [2:0]  sreg;
      logic [3:0]  base;
      logic [15:0] disp;
      logic [15:0] imm;
      logic        wide;
      logic [3:0]  cond;
      logic [7:0]  jofs;
      logic        err;
      logic [15:0] ip;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] start_ip = '0;
   logic        req;
   logic [15:0] req_addr;
   logic        mvalid = 1'b0;
   logic [7:0]  mbyte = '0;
   logic        done, err, wide;
   logic [2:0]  op, dreg, sreg;
   logic [1:0]  dk, sk;
   logic [3:0]  base, cond;
   logic [15:0] disp, imm, ip;
   logic [7:0]  jofs;

   logic [7:0]  mem [256];
   exp_t        q[$];
   int          n_chk = 0, n_fail = 0, pops = 0, issued = 0, cyc = 0;
   logic [15:0] wp = 16'h00F8;
   logic [15:0] cur = 16'h00F8;
   logic [3:0]  stall = '0;

   always #2.5 clk = ~clk;

   ixd_decoder #(.IP_W(16), .ACC_ALU_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .start_ip_i(start_ip),
      .req_o(req), .req_addr_o(req_addr), .mem_valid_i(mvalid), .mem_byte_i(mbyte),
      .done_o(done), .err_o(err), .op_o(op), .dst_kind_o(dk), .dst_reg_o(dreg),
      .src_kind_o(sk), .src_reg_o(sreg), .mem_base_o(base), .disp_o(disp),
      .imm_o(imm), .wide_o(wide), .cond_o(cond), .jofs_o(jofs), .ip_o(ip)
   );

   task automatic chk(input string tag, input string f, input int act, input int expv);
      n_chk++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, f, act, expv);
      end
   endtask

   // memory responder: stalls on a rotating phase
   always @(negedge clk) begin
      stall  = stall + 4'd1;
      mvalid = req && (stall[1:0] != 2'b01) && (stall != 4'd6);
      mbyte  = mem[req_addr[7:0]];
   end

   // monitor
   always @(negedge clk) begin
      if (done) begin
         if (q.size() == 0) begin
            chk("R11", "unexpected done", 1, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(e.tag, "err", err, e.err);
            chk(e.tag, "ip", ip, e.ip);
            if (!e.err) begin
               chk(e.tag, "op", op, e.op);
               chk(e.tag, "dst_kind", dk, e.dk);
               chk(e.tag, "dst_reg", dreg, e.dreg);
               chk(e.tag, "src_kind", sk, e.sk);
               chk(e.tag, "src_reg", sreg, e.sreg);
               chk(e.tag, "base", base, e.base);
               chk(e.tag, "disp", disp, e.disp);
               chk(e.tag, "imm", imm, e.imm);
               chk(e.tag, "wide", wide, e.wide);
               chk(e.tag, "cond", cond, e.cond);
               chk(e.tag, "jofs", jofs, e.jofs);
            end
         end
         pops++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual %0d expected <=50000 cycles", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic put(input logic [7:0] bv);
      mem[wp[7:0]] = bv;
      wp = wp + 16'd1;
   endtask

   function automatic exp_t mk(input logic [2:0] o, input logic [1:0] k1, input logic [2:0] r1,
                               input logic [1:0] k2, input logic [2:0] r2, input logic [3:0] bs,
                               input logic [15:0] dsp, input logic [15:0] im, input logic w,
                               input string tag);
      exp_t e;
      e.op = o; e.dk = k1; e.dreg = r1; e.sk = k2; e.sreg = r2; e.base = bs;
      e.disp = dsp; e.imm = im; e.wide = w; e.cond = '0; e.jofs = '0; e.err = 1'b0;
      e.ip = '0; e.tag = tag;
      return e;
   endfunction

   // driver: queue expectation, launch, wait for the monitor
   task automatic run(input exp_t e);
      e.ip = wp;
      q.push_back(e);
      issued++;
      @(negedge clk); start = 1'b1; start_ip = cur;
      @(negedge clk); start = 1'b0;
      wait (pops == issued);
      cur = wp;
      repeat (3) @(negedge clk);
   endtask

   function automatic exp_t mkerr(input string tag);
      exp_t e;
      e = mk(0, 2, 0, 3, 0, 0, 0, 0, 0, tag);
      e.err = 1'b1;
      return e;
   endfunction

   initial begin
      exp_t e;
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "done", done, 0);
      chk("R1", "req", req, 0);
      chk("R1", "err", err, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 reg-to-reg, d=0, wide
      put(8'h89); put(8'hD8);
      run(mk(0, 0, 0, 0, 3, 0, 16'h0000, 0, 1, "R2 89D8"));
      // R3 mod01 negative displacement, d=1
      put(8'h8B); put(8'h46); put(8'hFE);
      run(mk(0, 0, 0, 1, 0, 6, 16'hFFFE, 0, 1, "R3 disp8"));
      // R3 mod10 sixteen-bit displacement, byte width
      put(8'h8A); put(8'h87); put(8'h34); put(8'h12);
      run(mk(0, 0, 0, 1, 0, 7, 16'h1234, 0, 0, "R3 disp16"));
      // R4 direct address store
      put(8'h88); put(8'h0E); put(8'h00); put(8'h10);
      run(mk(0, 1, 0, 0, 1, 8, 16'h1000, 0, 0, "R4 direct"));
      // R4 mod00 without displacement
      put(8'h8B); put(8'h07);
      run(mk(0, 0, 0, 1, 0, 7, 16'h0000, 0, 1, "R4 nodisp"));
      // R5 immediate to direct memory, word
      put(8'hC7); put(8'h06); put(8'hE8); put(8'h03); put(8'h01); put(8'h00);
      run(mk(0, 1, 0, 2, 0, 8, 16'h03E8, 16'h0001, 1, "R5 word"));
      // R5 byte immediate stays zero-extended
      put(8'hC6); put(8'h47); put(8'h04); put(8'hFF);
      run(mk(0, 1, 0, 2, 0, 7, 16'h0004, 16'h00FF, 0, "R5 byte"));
      // R6 group forms
      put(8'h83); put(8'hC6); put(8'h02);
      run(mk(1, 0, 6, 2, 0, 0, 0, 16'h0002, 1, "R6 add sext"));
      put(8'h83); put(8'hEE); put(8'hFE);
      run(mk(2, 0, 6, 2, 0, 0, 0, 16'hFFFE, 1, "R6 sub sext"));
      put(8'h81); put(8'hFE); put(8'h00); put(8'h10);
      run(mk(3, 0, 6, 2, 0, 0, 0, 16'h1000, 1, "R6 cmp imm16"));
      put(8'h80); put(8'h3E); put(8'h10); put(8'h00); put(8'h7F);
      run(mk(3, 1, 0, 2, 0, 8, 16'h0010, 16'h007F, 0, "R6 cmp direct"));
      put(8'h83); put(8'hD8);
      run(mkerr("R6 bad field"));
      // R7 conditional jump
      put(8'h75); put(8'hF9);
      e = mk(4, 2, 0, 3, 0, 0, 0, 0, 0, "R7 jcc");
      e.cond = 4'h5; e.jofs = 8'hF9;
      run(e);
      // R8 loop jump
      put(8'hE2); put(8'hFC);
      e = mk(5, 2, 0, 3, 0, 0, 0, 0, 0, "R8 loop");
      e.cond = 4'h2; e.jofs = 8'hFC;
      run(e);
      // R9 accumulator forms
      put(8'hA1); put(8'hE8); put(8'h03);
      run(mk(0, 0, 0, 1, 0, 8, 16'h03E8, 0, 1, "R9 load"));
      put(8'hA2); put(8'h34); put(8'h12);
      run(mk(0, 1, 0, 0, 0, 8, 16'h1234, 0, 0, "R9 store"));
      // R10 immediate to register
      put(8'hBB); put(8'hE8); put(8'h03);
      run(mk(0, 0, 3, 2, 0, 0, 0, 16'h03E8, 1, "R10 word"));
      put(8'hB1); put(8'h0C);
      run(mk(0, 0, 1, 2, 0, 0, 0, 16'h000C, 0, "R10 byte"));
      // R12 unknown opcodes
      put(8'h0F);
      run(mkerr("R12 0F"));
      put(8'hF4);
      run(mkerr("R12 F4"));
      put(8'h08);
      run(mkerr("R12 08"));
      // R2 ALU register forms
      put(8'h01); put(8'hD9);
      run(mk(1, 0, 1, 0, 3, 0, 0, 0, 1, "R2 add rr"));
      put(8'h2B); put(8'h46); put(8'h02);
      run(mk(2, 0, 0, 1, 0, 6, 16'h0002, 0, 1, "R2 sub mem"));
      // accumulator immediate arithmetic (R6 ops, R11 length)
      put(8'h2D); put(8'h02); put(8'h00);
      run(mk(2, 0, 0, 2, 0, 0, 0, 16'h0002, 1, "R11 sub acc"));
      put(8'h3C); put(8'h05);
      run(mk(3, 0, 0, 2, 0, 0, 0, 16'h0005, 0, "R11 cmp acc"));

      repeat (5) @(negedge clk);
      // R11 no stray done after the last record
      chk("R11", "extra done", pops, issued);
      chk("R13", "idle req", req, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule